// File: doc/BRIEF.md
# Dual-Diagonal LDPC Systematic Encoder

This block is a serial systematic encoder for a short, high-rate LDPC code whose check matrix has a dual-diagonal parity part. Because of that shape, each parity bit equals the parity bit before it XORed with a small, row-specific set of information bits. A frame starts with a start strobe. The block then takes pilot bits and information bits one at a time over a valid/ready input and forwards them unchanged. While it forwards the information bits it also stores them. Once all of them have arrived, it produces the parity bits one per enabled cycle and then appends a single zero pad bit.

All parity bits come from one shared XOR reduction unit with `D_MAX + 1` inputs. For each parity row, the row counter picks which stored information bits feed that unit, using a constant ROM of column indices. The ROM is computed at elaboration from `TAB_SEED` by `ldpc_enc_pkg::tab_entry`. Rows that use fewer than `D_MAX` columns carry an all-ones "unused" marker in the spare slots, and those slots feed a zero into the unit. Output bits are packed two per word, one word per symbol. The bit generator advances only on cycles where the clock enable `ce` is high, and `ce` is normally driven at half the sample rate. The default code has 175 information bits and 80 parity bits, so the codeword is 255 bits. The pad bit brings it to 256 bits.

Top module: `ldpc_dd_encoder`

## Requirements
- R1: After reset, `out_valid`, `in_ready` and `frame_done` are all 0, and they stay 0 until a start strobe arrives.
- R2: A start strobe seen while the encoder is idle begins a frame. A start strobe seen during a frame is ignored: the frame still consumes exactly `N_PILOT + N_INFO` input bits, and afterwards the block returns to idle with `in_ready` at 0.
- R3: The first `N_PILOT` output bits are the pilot inputs and the next `N_INFO` bits are the information inputs, unchanged and in arrival order. Within a word, the earlier bit is `out_data[1]` and the later bit is `out_data[0]`.
- R4: Information bit i is the (N_PILOT+i)-th input bit, counting from 0. Parity bit j (j = 0..N_PAR-1) follows the information bits and satisfies p_j = p_{j-1} XOR (XOR of d_c over every in-range column c listed for row j), with p_{-1} = 0. Column c of row j is `tab_entry(TAB_SEED, N_INFO, D_MAX, j, k)` for k = 0..D_MAX-1. The value 32'hFFFFFFFF marks an unused slot and contributes 0.
- R5: The last bit of a frame is a 0 pad bit. A frame is exactly (N_PILOT+N_INFO+N_PAR+1)/2 words, and this total bit count must be even.
- R6: `frame_done` is a one-cycle pulse. It is raised in the cycle in which the word holding the pad bit first appears on the output, and it is raised once per frame.
- R7: `in_ready` is high only while pilot or information bits are being accepted, and only in cycles where `ce` is high. No input bit is taken while `ce` is low.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for the bit generator (half the sample rate) |
| start | input | 1 | Frame start strobe, honoured only when idle |
| in_valid | input | 1 | Input bit valid |
| in_bit | input | 1 | Pilot or information bit |
| in_ready | output | 1 | Encoder accepts `in_bit` this cycle |
| out_data | output | 2 | Codeword bit pair, earlier bit in bit 1 |
| out_valid | output | 1 | `out_data` holds a word |
| out_ready | input | 1 | Downstream accepts the word |
| frame_done | output | 1 | Pulse with the final word of a frame |

## Verification
The bench builds the encoder with 3 pilot bits, 12 information bits, 6 parity rows, `D_MAX` = 4 and seed 5. The frame is then only 11 words long. The generated table mixes row weights from 1 to 4, so every row's syndrome can be checked over GF(2), including rows with unused slots. With frames this short, the bench can run many of them under constant, half-rate and random `ce` and random output back-pressure. It can also place a stray start strobe in the middle of a frame and use all-zero, all-one, alternating and random data within the budget.

// File: rtl/ldpc_enc_pkg.sv
package ldpc_enc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PILOT, ST_INFO, ST_PARITY, ST_PAD
  } enc_state_t;

  localparam int unsigned UNUSED_ENT = 32'hFFFF_FFFF;

  // Column index used by slot k of parity row r, or UNUSED_ENT.
  // Row weight runs from 1 to d_max, chosen per row.
  function automatic int unsigned tab_entry(input int unsigned seed, input int unsigned n_info,
                                            input int unsigned d_max, input int unsigned r,
                                            input int unsigned k);
    int unsigned h;
    int unsigned w;
    h = seed * 32'd2654435761 + r * 32'd40503 + k * 32'd9973 + 32'd17;
    h = h ^ (h >> 13);
    h = h * 32'd2246822519;
    h = h ^ (h >> 16);
    w = 1 + ((r * 3 + seed) % d_max);
    if (k >= w) return UNUSED_ENT;
    return h % n_info;
  endfunction

endpackage

// File: rtl/enc_ctrl.sv
module enc_ctrl
  import ldpc_enc_pkg::*;
#(
  parameter int N_PILOT = 16,
  parameter int N_INFO  = 175,
  parameter int N_PAR   = 80,
  localparam int CNT_MAX = (N_PILOT > N_INFO) ? ((N_PILOT > N_PAR) ? N_PILOT : N_PAR)
                                              : ((N_INFO > N_PAR) ? N_INFO : N_PAR),
  localparam int CW = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          start,
  input  logic          in_valid,
  input  logic          can_push,
  output enc_state_t    state,
  output logic [CW-1:0] cnt,
  output logic          in_ready,
  output logic          step
);

  logic          load;
  logic [CW-1:0] lim;
  logic          last;

  assign load     = (state == ST_PILOT) || (state == ST_INFO);
  assign in_ready = ce && can_push && load;
  assign step     = ce && can_push &&
                    (load ? in_valid : ((state == ST_PARITY) || (state == ST_PAD)));

  always_comb begin
    case (state)
      ST_PILOT:  lim = CW'(N_PILOT);
      ST_INFO:   lim = CW'(N_INFO);
      ST_PARITY: lim = CW'(N_PAR);
      default:   lim = CW'(1);
    endcase
  end
  assign last = (cnt == lim - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (state == ST_IDLE) begin
      cnt <= '0;
      if (start) state <= ST_PILOT;
    end else if (step) begin
      if (last) begin
        cnt <= '0;
        case (state)
          ST_PILOT:  state <= ST_INFO;
          ST_INFO:   state <= ST_PARITY;
          ST_PARITY: state <= ST_PAD;
          default:   state <= ST_IDLE;
        endcase
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !in_ready); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INFO && !step) |=> (state == ST_INFO) && $stable(cnt)); // R2
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PARITY) |-> (cnt < CW'(N_PAR))); // R4

endmodule

// File: rtl/enc_xor_unit.sv
module enc_xor_unit
  import ldpc_enc_pkg::*;
#(
  parameter int N_INFO   = 175,
  parameter int N_PAR    = 80,
  parameter int D_MAX    = 16,
  parameter int TAB_SEED = 1,
  localparam int COL_W = $clog2(N_INFO + 1),
  localparam int RW    = (N_PAR > 1) ? $clog2(N_PAR) : 1
) (
  input  logic [N_INFO-1:0] ibuf,
  input  logic [RW-1:0]     row,
  input  logic              prev,
  output logic              par_bit
);

  logic [COL_W-1:0] rom [N_PAR][D_MAX];
  logic [D_MAX-1:0] sel;

  // Constant column ROM, all-ones marks an unused slot
  for (genvar r = 0; r < N_PAR; r++) begin : g_row
    for (genvar k = 0; k < D_MAX; k++) begin : g_slot
      localparam int unsigned ENT = tab_entry(TAB_SEED, N_INFO, D_MAX, r, k);
      assign rom[r][k] = (ENT == UNUSED_ENT) ? '1 : COL_W'(ENT);
    end
  end

  // One selector per XOR input; unused slots feed 0
  for (genvar k = 0; k < D_MAX; k++) begin : g_sel
    logic [COL_W-1:0] col;
    assign col    = rom[row][k];
    assign sel[k] = (col == '1) ? 1'b0 : ibuf[col];
  end

  assign par_bit = prev ^ (^sel);

endmodule

// File: rtl/enc_pair_pack.sv
module enc_pair_pack (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic       bit_in,
  output logic       can_push,
  output logic [1:0] out_data,
  output logic       out_valid,
  input  logic       out_ready
);

  logic half;
  logic hold;

  assign can_push = !half || !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      half      <= 1'b0;
      hold      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= 2'b00;
    end else begin
      if (out_ready) out_valid <= 1'b0;
      if (push) begin
        if (!half) begin
          hold <= bit_in;
          half <= 1'b1;
        end else begin
          out_data  <= {hold, bit_in};
          out_valid <= 1'b1;
          half      <= 1'b0;
        end
      end
    end
  end

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R8

endmodule

// File: rtl/ldpc_dd_encoder.sv
module ldpc_dd_encoder
  import ldpc_enc_pkg::*;
#(
  parameter int N_PILOT  = 16,
  parameter int N_INFO   = 175,
  parameter int N_PAR    = 80,
  parameter int D_MAX    = 16,
  parameter int TAB_SEED = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce,
  input  logic       start,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic [1:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       frame_done
);

  localparam int CNT_MAX = (N_PILOT > N_INFO) ? ((N_PILOT > N_PAR) ? N_PILOT : N_PAR)
                                              : ((N_INFO > N_PAR) ? N_INFO : N_PAR);
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int RW = (N_PAR > 1) ? $clog2(N_PAR) : 1;

  enc_state_t        state;
  logic [CW-1:0]     cnt;
  logic              step;
  logic              can_push;
  logic [N_INFO-1:0] ibuf;
  logic              prev_par;
  logic              par_bit;
  logic              push_bit;

  enc_ctrl #(.N_PILOT(N_PILOT), .N_INFO(N_INFO), .N_PAR(N_PAR)) u_ctrl (
    .clk(clk), .rst(rst), .ce(ce), .start(start), .in_valid(in_valid),
    .can_push(can_push), .state(state), .cnt(cnt), .in_ready(in_ready), .step(step)
  );

  enc_xor_unit #(.N_INFO(N_INFO), .N_PAR(N_PAR), .D_MAX(D_MAX), .TAB_SEED(TAB_SEED)) u_xor (
    .ibuf(ibuf), .row(cnt[RW-1:0]), .prev(prev_par), .par_bit(par_bit)
  );

  // Information buffer and parity recursion state
  always_ff @(posedge clk) begin
    if (rst) begin
      ibuf     <= '0;
      prev_par <= 1'b0;
    end else begin
      if (state == ST_IDLE) prev_par <= 1'b0;
      if (step && state == ST_INFO) ibuf[cnt] <= in_bit;
      if (step && state == ST_PARITY) prev_par <= par_bit;
    end
  end

  always_comb begin
    case (state)
      ST_PARITY: push_bit = par_bit;
      ST_PAD:    push_bit = 1'b0;
      default:   push_bit = in_bit;
    endcase
  end

  enc_pair_pack u_pack (
    .clk(clk), .rst(rst), .push(step), .bit_in(push_bit), .can_push(can_push),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) frame_done <= 1'b0;
    else     frame_done <= step && (state == ST_PAD);
  end

  AST_READY_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> ce); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R6
  AST_DONE_PAD_WORD: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> out_valid && !out_data[0]); // R5

endmodule

// File: tb/sim_ldpc_dd_encoder.sv
module sim_ldpc_dd_encoder;
  import ldpc_enc_pkg::*;

  localparam int NP = 3, NI = 12, NR = 6, DM = 4, SEED = 5;
  localparam int NB = NP + NI + NR + 1;
  localparam int NW = NB / 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, ce = 1'b0, start = 1'b0, in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, frame_done;
  logic [1:0] out_data;

  ldpc_dd_encoder #(.N_PILOT(NP), .N_INFO(NI), .N_PAR(NR), .D_MAX(DM), .TAB_SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .start(start), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .frame_done(frame_done)
  );

  int checks = 0, fails = 0;
  bit src [NP+NI];
  bit got [NB];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int syndrome_errors();
    int bad = 0;
    for (int r = 0; r < NR; r++) begin
      bit s = got[NP+NI+r];
      if (r > 0) s ^= got[NP+NI+r-1];
      for (int k = 0; k < DM; k++) begin
        int unsigned e = tab_entry(SEED, NI, DM, r, k);
        if (e != UNUSED_ENT) s ^= got[NP+int'(e)];
      end
      if (s) bad++;
    end
    return bad;
  endfunction

  task automatic run_frame(input int dmode, input int cemode, input bit bp, input bit mid_start);
    int sent = 0, nw = 0, dones = 0, guard = 0, ce_bad = 0, bp_bad = 0, done_pos = -1, mism = 0;
    bit hold_v = 0;
    logic [1:0] hold_d = 2'b00;
    for (int i = 0; i < NP + NI; i++) begin
      case (dmode)
        0: src[i] = 1'($urandom);
        1: src[i] = 1'b0;
        2: src[i] = 1'b1;
        default: src[i] = 1'(i % 2);
      endcase
    end
    @(negedge clk); start = 1'b1; ce = 1'b1;
    @(negedge clk); start = 1'b0;
    while (nw < NW && guard < 4000) begin
      @(negedge clk);
      guard++;
      case (cemode)
        0: ce = 1'b1;
        1: ce = ~ce;
        default: ce = ($urandom % 3) != 0;
      endcase
      out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
      in_valid  = ($urandom % 4) != 0;
      in_bit    = (sent < NP + NI) ? src[sent] : 1'b0;
      start     = mid_start && (guard == 12);
      #1;
      if (hold_v && (!out_valid || out_data != hold_d)) bp_bad++;
      hold_v = out_valid && !out_ready;
      hold_d = out_data;
      if (in_ready && !ce) ce_bad++;
      if (frame_done) begin dones++; done_pos = nw; end
      if (in_valid && in_ready) sent++;
      if (out_valid && out_ready) begin
        got[2*nw] = out_data[1]; got[2*nw+1] = out_data[0]; nw++;
      end
    end
    start = 1'b0;
    if (guard >= 4000) chk(0, "WDOG", "frame hung, words", nw, NW);
    for (int i = 0; i < NP + NI; i++) if (got[i] != src[i]) mism++;
    chk(mism == 0, "R3", "pass-through mismatches", mism, 0);
    chk(syndrome_errors() == 0, "R4", "failing check rows", syndrome_errors(), 0);
    chk(got[NB-1] == 1'b0, "R5", "pad bit", int'(got[NB-1]), 0);
    chk(dones == 1, "R6", "frame_done pulses", dones, 1);
    chk(done_pos == NW - 1, "R6", "word index at frame_done", done_pos, NW - 1);
    chk(ce_bad == 0, "R7", "in_ready while ce low", ce_bad, 0);
    chk(sent == NP + NI, "R2", "input bits consumed", sent, NP + NI);
    chk(bp_bad == 0, "R8", "output changed under back-pressure", bp_bad, 0);
    // after the frame: idle, no extra words, stray start had no effect
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ce = 1'b1; out_ready = 1'b1; in_valid = 1'b1; #1;
      chk(!out_valid && !in_ready, "R5", "activity after frame end", int'(out_valid) + int'(in_ready), 0);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    ce = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1'b1; out_ready = 1'b1; #1;
      chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
      chk(!in_ready, "R1", "in_ready after reset", int'(in_ready), 0);
      chk(!frame_done, "R1", "frame_done after reset", int'(frame_done), 0);
    end
    in_valid = 1'b0;
    run_frame(1, 0, 1'b0, 1'b0);  // all zero, full rate
    run_frame(2, 1, 1'b0, 1'b0);  // all ones, half-rate enable
    run_frame(3, 0, 1'b1, 1'b1);  // alternating, back-pressure, stray start
    for (int f = 0; f < 12; f++) run_frame(0, f % 3, f[0], f[1]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL WDOG global watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule